// File: doc/BRIEF.md
# Frame-Synchronised Double-Buffered Control Register Bank

This block holds a small bank of control registers that a host writes in its own clock domain and that processing logic reads in a separate consumer clock domain. Each register has a staging copy and an active copy. Host writes land only in the staging copies. A store request takes a snapshot of every staging value and sends it across to the consumer domain. The snapshot is copied into the active copies on the next frame (vertical) sync pulse of that domain. Every buffered setting therefore changes at the same frame boundary, never part-way through a frame.

Two per-register masks, fixed at elaboration, adjust this behaviour. Registers marked immediate skip the buffering: their active value follows the host write at once. Registers left out of the commit mask belong to another domain's bank. This instance never updates their active value. A store made while an earlier commit is still in flight is held. It goes out after the acknowledge returns and lands on the next frame sync after that. The host reads back staging values and sees a pending flag while any store has not yet been applied.

Top module: `frame_commit_regbank`

## Requirements
- R1: After reset, every active output and every readback value equals its register's default (register i defaults to the byte whose two nibbles both equal i), and `commit_pending` is 0.
- R2: A host write updates the staging copy. `rd_data` returns the staging value of `rd_addr` one host cycle after the address is presented.
- R3: A host write to a buffered register does not change its active output while no store has been issued, even when frame-sync pulses arrive.
- R4: `commit_pending` is 1 on the host cycle after a store. Active outputs keep their old values until a frame-sync pulse arrives in the consumer domain.
- R5: On the first `vsync` consumer edge after the store reaches the consumer domain, every committed register takes its snapshot value in that same cycle.
- R6: A register in `IMM_MASK` (default: register 7) shows a host write on its active output on the host cycle after the write, with no store and no frame sync.
- R7: A non-immediate register outside `COMMIT_MASK` (default: register 6) keeps its default active value through store and commit. Its staging copy still reads back the written value.
- R8: A store issued while an earlier commit is still in flight is neither lost nor merged into that earlier commit. The earlier commit applies the first snapshot. The held store is applied at a later frame sync with the staging values current when it is launched, and `commit_pending` stays 1 until it lands.
- R9: `commit_pending` returns to 0 within a bounded number of host cycles after the last outstanding commit has been applied.
- R10: Host writes made after a store has launched do not enter that store's commit. Only the staging values held at launch are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host-side clock |
| host_rst | input | 1 | Synchronous active-high reset, host domain |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | log2(NUM_REGS) | Register index to write |
| wr_data | input | DATA_W | Write data |
| store | input | 1 | Store request pulse (snapshot and commit) |
| rd_addr | input | log2(NUM_REGS) | Register index to read back |
| rd_data | output | DATA_W | Staging value, registered |
| commit_pending | output | 1 | A store has not yet been applied |
| cons_clk | input | 1 | Consumer-side clock |
| cons_rst | input | 1 | Synchronous active-high reset, consumer domain |
| vsync | input | 1 | Frame-sync pulse, consumer domain |
| act_o | output | NUM_REGS*DATA_W | Active values, register i at bits [i*DATA_W +: DATA_W] |

## Verification
The bench runs a host write with frame syncs but no store; a design that leaked staging into the active copies would change outputs mid-frame. It writes a register again after a store, before the sync. A design that sampled staging at commit time instead of at launch would apply the newer value. Back-to-back stores check that the second one is held, then applied on a later sync with its own data. A design that dropped the held store would leave the old value in place and clear pending too early. Separate checks cover the immediate register and the register outside the commit mask, so that a swapped mask shows up.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int unsigned SYNC_DEPTH_DEF = 2;

  function automatic int unsigned idx_w(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction
endpackage

// File: rtl/frc_sync.sv
module frc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/frc_host_side.sv
module frc_host_side #(
  parameter int unsigned N  = 8,
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 3,
  parameter logic [N*W-1:0] RST_VAL = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [W-1:0]        wr_data,
  input  logic                store,
  input  logic [AW-1:0]       rd_addr,
  output logic [W-1:0]        rd_data,
  output logic                pending_o,
  input  logic                ack_s,
  output logic                req_t,
  output logic [N-1:0][W-1:0] stage_q,
  output logic [N-1:0][W-1:0] shadow_q
);
  logic deferred_q;
  logic busy, launch, req_nxt, def_nxt;

  always_comb begin
    busy    = req_t ^ ack_s;
    launch  = !busy && (store || deferred_q);
    req_nxt = req_t ^ launch;
    def_nxt = launch ? 1'b0 : (deferred_q | store);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q    <= RST_VAL;
      shadow_q   <= RST_VAL;
      req_t      <= 1'b0;
      deferred_q <= 1'b0;
      pending_o  <= 1'b0;
      rd_data    <= '0;
    end else begin
      for (int i = 0; i < int'(N); i++) begin
        if (wr_en && int'(wr_addr) == i) stage_q[i] <= wr_data;
      end
      if (launch) shadow_q <= stage_q;
      req_t      <= req_nxt;
      deferred_q <= def_nxt;
      pending_o  <= (req_nxt ^ ack_s) | def_nxt;
      rd_data    <= (int'(rd_addr) < int'(N)) ? stage_q[rd_addr] : '0;
    end
  end

  p_store_pending_r4: assert property (@(posedge clk) disable iff (rst)
    store |=> pending_o)
    else $error("store did not raise pending");

  p_shadow_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    (req_t != ack_s) |=> $stable(shadow_q))
    else $error("snapshot changed while commit in flight");
endmodule

// File: rtl/frc_cons_side.sv
module frc_cons_side #(
  parameter int unsigned N = 8,
  parameter int unsigned W = 8,
  parameter logic [N-1:0] IMM_MASK    = '0,
  parameter logic [N-1:0] COMMIT_MASK = '1,
  parameter logic [N*W-1:0] RST_VAL   = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                vsync,
  input  logic                req_s,
  input  logic [N-1:0][W-1:0] shadow_i,
  input  logic [N-1:0][W-1:0] stage_i,
  output logic                ack_t,
  output logic [N*W-1:0]      act_o
);
  logic commit;
  logic [N-1:0][W-1:0] act_q;
  wire unused_inputs = ^{shadow_i, stage_i};

  assign commit = vsync && (req_s ^ ack_t);

  always_ff @(posedge clk) begin
    if (rst)         ack_t <= 1'b0;
    else if (commit) ack_t <= req_s;
  end

  for (genvar i = 0; i < int'(N); i++) begin : g_reg
    if (COMMIT_MASK[i] && !IMM_MASK[i]) begin : g_buf
      always_ff @(posedge clk) begin
        if (rst)         act_q[i] <= RST_VAL[i*W +: W];
        else if (commit) act_q[i] <= shadow_i[i];
      end
    end else begin : g_fixed
      assign act_q[i] = RST_VAL[i*W +: W];
    end

    if (IMM_MASK[i]) begin : g_imm
      assign act_o[i*W +: W] = stage_i[i];
    end else begin : g_act
      assign act_o[i*W +: W] = act_q[i];
    end
  end

  p_hold_between_syncs_r3: assert property (@(posedge clk) disable iff (rst)
    !vsync |=> $stable(act_q))
    else $error("active copy changed without frame sync");

  p_ack_on_sync_r5: assert property (@(posedge clk) disable iff (rst)
    !vsync |=> $stable(ack_t))
    else $error("commit acknowledged without frame sync");
endmodule

// File: rtl/frame_commit_regbank.sv
module frame_commit_regbank
  import frc_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH_DEF,
  parameter logic [NUM_REGS-1:0] IMM_MASK    = 8'h80,
  parameter logic [NUM_REGS-1:0] COMMIT_MASK = 8'h3F,
  parameter logic [NUM_REGS*DATA_W-1:0] RESET_VALS = 64'h7766_5544_3322_1100
) (
  input  logic                           host_clk,
  input  logic                           host_rst,
  input  logic                           wr_en,
  input  logic [idx_w(NUM_REGS)-1:0]     wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic                           store,
  input  logic [idx_w(NUM_REGS)-1:0]     rd_addr,
  output logic [DATA_W-1:0]              rd_data,
  output logic                           commit_pending,
  input  logic                           cons_clk,
  input  logic                           cons_rst,
  input  logic                           vsync,
  output logic [NUM_REGS*DATA_W-1:0]     act_o
);
  localparam int unsigned AW = idx_w(NUM_REGS);

  logic req_t, req_s, ack_t, ack_s;
  logic [NUM_REGS-1:0][DATA_W-1:0] stage, shadow;

  frc_host_side #(.N(NUM_REGS), .W(DATA_W), .AW(AW), .RST_VAL(RESET_VALS)) u_host (
    .clk(host_clk), .rst(host_rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .store(store), .rd_addr(rd_addr), .rd_data(rd_data),
    .pending_o(commit_pending), .ack_s(ack_s), .req_t(req_t),
    .stage_q(stage), .shadow_q(shadow));

  frc_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(cons_clk), .rst(cons_rst), .d_i(req_t), .q_o(req_s));

  frc_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(host_clk), .rst(host_rst), .d_i(ack_t), .q_o(ack_s));

  frc_cons_side #(.N(NUM_REGS), .W(DATA_W), .IMM_MASK(IMM_MASK),
                  .COMMIT_MASK(COMMIT_MASK), .RST_VAL(RESET_VALS)) u_cons (
    .clk(cons_clk), .rst(cons_rst), .vsync(vsync), .req_s(req_s),
    .shadow_i(shadow), .stage_i(stage), .ack_t(ack_t), .act_o(act_o));

  for (genvar i = 0; i < int'(NUM_REGS); i++) begin : g_imm_chk
    if (IMM_MASK[i]) begin : g_on
      p_imm_follow_r6: assert property (@(posedge host_clk) disable iff (host_rst)
        (wr_en && int'(wr_addr) == i) |=> (act_o[i*DATA_W +: DATA_W] == $past(wr_data)))
        else $error("immediate register did not follow write");
    end
  end
endmodule

// File: tb/frame_commit_regbank_tb.sv
module frame_commit_regbank_tb;
  logic host_clk = 0, cons_clk = 0;
  logic host_rst = 1, cons_rst = 1;
  logic wr_en = 0, store = 0, vsync = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic commit_pending;
  logic [63:0] act_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 host_clk = ~host_clk;
  always #7 cons_clk = ~cons_clk;

  frame_commit_regbank u_dut (
    .host_clk(host_clk), .host_rst(host_rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .store(store), .rd_addr(rd_addr), .rd_data(rd_data),
    .commit_pending(commit_pending), .cons_clk(cons_clk), .cons_rst(cons_rst),
    .vsync(vsync), .act_o(act_o));

  function automatic logic [7:0] dflt(input int i);
    return 8'(i * 17);
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] act(input int i);
    return act_o[i*8 +: 8];
  endfunction

  task automatic wait_host(input int n); repeat (n) @(negedge host_clk); endtask
  task automatic wait_cons(input int n); repeat (n) @(negedge cons_clk); endtask

  task automatic host_write(input int a, input logic [7:0] d);
    @(negedge host_clk); wr_en = 1; wr_addr = 3'(a); wr_data = d;
    @(negedge host_clk); wr_en = 0;
  endtask

  task automatic host_store();
    @(negedge host_clk); store = 1;
    @(negedge host_clk); store = 0;
  endtask

  task automatic pulse_vsync();
    @(negedge cons_clk); vsync = 1;
    @(negedge cons_clk); vsync = 0;
  endtask

  task automatic read_back(input int a, output logic [7:0] v);
    @(negedge host_clk); rd_addr = 3'(a);
    @(negedge host_clk); v = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) chk($sformatf("R1 active %0d", i), act(i), dflt(i));
    for (int i = 0; i < 8; i++) begin
      read_back(i, v);
      chk($sformatf("R1 readback %0d", i), v, dflt(i));
    end
    chk("R1 pending", {7'd0, commit_pending}, 8'd0);
  endtask

  task automatic t_readback_no_store();
    logic [7:0] v;
    host_write(2, 8'hA5);
    read_back(2, v);
    chk("R2 readback staging", v, 8'hA5);
    pulse_vsync(); pulse_vsync();
    wait_cons(2);
    chk("R3 active unchanged without store", act(2), 8'h22);
    chk("R3 no pending", {7'd0, commit_pending}, 8'd0);
  endtask

  task automatic t_store_commit();
    host_write(0, 8'hC3);
    host_store();
    chk("R4 pending after store", {7'd0, commit_pending}, 8'd1);
    wait_cons(8);
    chk("R4 reg2 held before sync", act(2), 8'h22);
    chk("R4 reg0 held before sync", act(0), 8'h00);
    pulse_vsync();
    chk("R5 reg2 committed", act(2), 8'hA5);
    chk("R5 reg0 committed", act(0), 8'hC3);
    wait_host(14);
    chk("R9 pending cleared", {7'd0, commit_pending}, 8'd0);
  endtask

  task automatic t_immediate();
    host_write(7, 8'hE1);
    chk("R6 immediate follows write", act(7), 8'hE1);
    chk("R6 no pending", {7'd0, commit_pending}, 8'd0);
  endtask

  task automatic t_untagged();
    logic [7:0] v;
    host_write(6, 8'h5A);
    host_store();
    wait_cons(8);
    pulse_vsync();
    wait_cons(2);
    chk("R7 untagged active kept", act(6), 8'h66);
    read_back(6, v);
    chk("R7 untagged staging", v, 8'h5A);
    wait_host(14);
  endtask

  task automatic t_snapshot();
    logic [7:0] v;
    host_write(1, 8'h10);
    host_store();
    wait_host(2);
    host_write(1, 8'h20);
    wait_cons(8);
    pulse_vsync();
    chk("R10 commit uses launch snapshot", act(1), 8'h10);
    wait_host(14);
    chk("R10 pending cleared", {7'd0, commit_pending}, 8'd0);
    read_back(1, v);
    chk("R10 staging keeps later write", v, 8'h20);
  endtask

  task automatic t_double_store();
    host_write(3, 8'h05);
    host_store();
    host_write(3, 8'h09);
    host_store();
    chk("R8 pending after second store", {7'd0, commit_pending}, 8'd1);
    wait_cons(8);
    pulse_vsync();
    chk("R8 first commit value", act(3), 8'h05);
    wait_host(16);
    chk("R8 pending held for second", {7'd0, commit_pending}, 8'd1);
    wait_cons(6);
    chk("R8 second waits for sync", act(3), 8'h05);
    pulse_vsync();
    chk("R8 second commit value", act(3), 8'h09);
    wait_host(14);
    chk("R8 pending cleared", {7'd0, commit_pending}, 8'd0);
  endtask

  initial begin
    repeat (6) @(negedge cons_clk);
    @(negedge host_clk); host_rst = 0;
    @(negedge cons_clk); cons_rst = 0;
    wait_host(3);
    t_reset();
    t_readback_no_store();
    t_store_commit();
    t_immediate();
    t_untagged();
    t_snapshot();
    t_double_store();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge host_clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule